// File: doc/BRIEF.md
# Configuration Access Guard with Security Lock and Signature Word

This block guards access to the configuration store of a reprogrammable logic device. One command port carries program, verify (readback), lock, bulk-erase and signature commands. The block decides per command whether configuration reads and writes may proceed. It keeps a one-way security bit that, once set, refuses every configuration readback and every reprogramming attempt. Only a full bulk erase clears that bit again.

Next to the configuration store sits a signature word that identifies the loaded pattern or its revision. The signature can be written only while the device is unlocked. It can be read back at any time, locked or not. A parameter selects a 24-bit signature or an extended 64-bit one. The real fuse array is modelled as a small register memory, and the erase as a fixed number of busy cycles.

Top module: `secure_cfg_access`

## Requirements
- R1: After reset every configuration word and the signature read as all ones, the lock is clear, `busy` is low, and `rdValid`, `rdData`, `denied`, `sigValid` and `sigRdData` are zero.
- R2: With the lock clear, a program command (`cmdOp`=1) stores `wrData` at `addr`. A verify command (`cmdOp`=3) drives `rdValid` high and the stored word on `rdData` in the cycle after the command. `denied` stays low.
- R3: The lock is set either by a lock command (`cmdOp`=4) or by a program-and-lock command (`cmdOp`=2), which stores `wrData` at `addr` and sets the lock at the same edge. `locked` is high from the cycle after.
- R4: While locked, a verify command gives `rdValid`=1 with `rdData` all zeros, and `denied` high for that one cycle.
- R5: While locked, program (1), program-and-lock (2) and signature-program (6) commands leave the configuration words and the signature unchanged, and raise `denied` for one cycle.
- R6: An erase command (`cmdOp`=5) raises `busy` from the next cycle for exactly ERASE_CYCLES cycles. When `busy` falls, every configuration word and the signature read as all ones and the lock is clear.
- R7: While `busy` is high, every command is ignored. No `rdValid`, `sigValid` or `denied` pulse appears, and no stored value changes.
- R8: A signature-read command (`cmdOp`=7) drives `sigValid` high and the signature on `sigRdData` in the next cycle, whether locked or not. `denied` stays low.
- R9: With the lock clear, a signature-program command (`cmdOp`=6) stores `sigWrData` as the signature.
- R10: The signature is 24 bits wide when SIG_WIDE is 0 and 64 bits wide when SIG_WIDE is 1, and all of its bits are stored and returned.
- R11: Once set, the lock stays set through any command other than erase. A lock command while already locked is not refused. A no-op command (`cmdOp`=0) does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command code (0 nop, 1 program, 2 program-and-lock, 3 verify, 4 lock, 5 erase, 6 signature program, 7 signature read) |
| addr | input | ADDR_W | Configuration word index |
| wrData | input | DATA_W | Data for program commands |
| sigWrData | input | SIG_W | Data for signature program |
| rdData | output | DATA_W | Verify result (zero when refused) |
| rdValid | output | 1 | Verify result valid, one cycle |
| sigRdData | output | SIG_W | Signature readback |
| sigValid | output | 1 | Signature readback valid, one cycle |
| denied | output | 1 | Command refused by the lock, one cycle |
| busy | output | 1 | Bulk erase in progress |
| locked | output | 1 | Security bit state |

## Verification
The bench builds the block with an 8-word store (ADDR_W=3), the 64-bit signature (SIG_WIDE=1) and a 5-cycle erase. With the small store, random addresses revisit every word often, so writes refused under the lock are caught on later readback. The wide signature exercises the upper 40 bits that the narrow variant lacks. The short erase lets the random mix pass through many lock, erase and unlock rounds, with commands fired into every busy cycle.

// File: rtl/secure_cfg_pkg.sv
package secure_cfg_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_PROG      = 3'd1,
    OP_PROG_LOCK = 3'd2,
    OP_VERIFY    = 3'd3,
    OP_LOCK      = 3'd4,
    OP_ERASE     = 3'd5,
    OP_SIG_PROG  = 3'd6,
    OP_SIG_READ  = 3'd7
  } cmd_op_e;

  typedef struct packed {
    logic cfgWr;
    logic cfgRd;
    logic lockSet;
    logic sigWr;
    logic sigRd;
    logic eraseDo;
    logic deny;
  } ctrl_strobes_t;

  function automatic int sigWidth(input bit wide);
    return wide ? 64 : 24;
  endfunction

endpackage

// File: rtl/secure_cfg_ctrl.sv
module secure_cfg_ctrl
  import secure_cfg_pkg::*;
#(
  parameter int ERASE_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic          lockedIn,
  output ctrl_strobes_t strobes,
  output logic          busy
);

  localparam int CNT_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

  cmd_op_e        op;
  logic           accept;
  logic           isCfgWrite;
  logic           isGuarded;
  logic           eraseStart;
  logic [CNT_W-1:0] eraseCnt;

  always_comb begin
    op         = cmd_op_e'(cmdOp);
    accept     = cmdValid && !busy;
    isCfgWrite = (op == OP_PROG) || (op == OP_PROG_LOCK);
    isGuarded  = isCfgWrite || (op == OP_SIG_PROG) || (op == OP_VERIFY);
    eraseStart = accept && (op == OP_ERASE);

    strobes.deny    = accept && lockedIn && isGuarded;
    strobes.cfgWr   = accept && !lockedIn && isCfgWrite;
    strobes.cfgRd   = accept && (op == OP_VERIFY);
    strobes.lockSet = accept && ((op == OP_LOCK) || ((op == OP_PROG_LOCK) && !lockedIn));
    strobes.sigWr   = accept && !lockedIn && (op == OP_SIG_PROG);
    strobes.sigRd   = accept && (op == OP_SIG_READ);
    strobes.eraseDo = busy && (eraseCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      eraseCnt <= '0;
    end else if (eraseStart) begin
      busy     <= 1'b1;
      eraseCnt <= CNT_LOAD;
    end else if (busy) begin
      if (eraseCnt == '0) begin
        busy <= 1'b0;
      end else begin
        eraseCnt <= eraseCnt - 1'b1;
      end
    end
  end

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(strobes.cfgWr || strobes.cfgRd || strobes.lockSet ||
               strobes.sigWr || strobes.sigRd || strobes.deny)); // R7

  AST_NO_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    lockedIn |-> !(strobes.cfgWr || strobes.sigWr)); // R5

  AST_ERASE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    strobes.eraseDo |=> !busy); // R6

  AST_DENY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    strobes.deny |-> lockedIn); // R4

endmodule

// File: rtl/secure_cfg_dp.sv
module secure_cfg_dp
  import secure_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobes_t     st,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SIG_W-1:0]  sigWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [SIG_W-1:0]  sigRdData,
  output logic              sigValid,
  output logic              denied,
  output logic              locked
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cfgMem [DEPTH];
  logic [SIG_W-1:0]  sigWord;
  logic [DATA_W-1:0] readWord;

  assign readWord = cfgMem[addr];

  // Configuration store: one register per word, erased value all ones.
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (rst || st.eraseDo) begin
        wordQ <= '1;
      end else if (st.cfgWr && (addr == ADDR_W'(w))) begin
        wordQ <= wrData;
      end
    end
    assign cfgMem[w] = wordQ;
  end

  always_ff @(posedge clk) begin
    if (rst || st.eraseDo) begin
      sigWord <= '1;
      locked  <= 1'b0;
    end else begin
      if (st.sigWr)   sigWord <= sigWrData;
      if (st.lockSet) locked  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      sigRdData <= '0;
      sigValid  <= 1'b0;
      denied    <= 1'b0;
    end else begin
      rdValid   <= st.cfgRd;
      rdData    <= (st.cfgRd && !st.deny) ? readWord : '0;
      sigValid  <= st.sigRd;
      sigRdData <= st.sigRd ? sigWord : '0;
      denied    <= st.deny;
    end
  end

  AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdValid && denied) |-> (rdData == '0)); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (locked && !st.eraseDo) |=> locked); // R11

  AST_ERASE_BLANKS: assert property (@(posedge clk) disable iff (rst)
    st.eraseDo |=> (!locked && (sigWord == '1))); // R6

  AST_LOCKED_SIG_STABLE: assert property (@(posedge clk) disable iff (rst)
    (locked && !st.eraseDo) |=> $stable(sigWord)); // R5

endmodule

// File: rtl/secure_cfg_access.sv
module secure_cfg_access
  import secure_cfg_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter bit SIG_WIDE     = 1'b0,
  parameter int ERASE_CYCLES = 16,
  localparam int SIG_W       = sigWidth(SIG_WIDE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SIG_W-1:0]  sigWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [SIG_W-1:0]  sigRdData,
  output logic              sigValid,
  output logic              denied,
  output logic              busy,
  output logic              locked
);

  ctrl_strobes_t strobes;

  secure_cfg_ctrl #(
    .ERASE_CYCLES(ERASE_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .lockedIn (locked),
    .strobes  (strobes),
    .busy     (busy)
  );

  secure_cfg_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SIG_W  (SIG_W)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .st        (strobes),
    .addr      (addr),
    .wrData    (wrData),
    .sigWrData (sigWrData),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .sigRdData (sigRdData),
    .sigValid  (sigValid),
    .denied    (denied),
    .locked    (locked)
  );

endmodule

// File: tb/test_secure_cfg_access.sv
`timescale 1ns/1ps
module test_secure_cfg_access;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int SIG_W  = 64;
  localparam int ERASE  = 5;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmdValid = 1'b0;
  logic [2:0]        cmdOp = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [SIG_W-1:0]  sigWrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;
  logic [SIG_W-1:0]  sigRdData;
  logic              sigValid;
  logic              denied;
  logic              busy;
  logic              locked;

  int total = 0;
  int bad   = 0;

  logic [DATA_W-1:0] mMem [DEPTH];
  logic [SIG_W-1:0]  mSig;
  logic              mLocked;

  always #10 clk = ~clk;

  secure_cfg_access #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_WIDE(1'b1), .ERASE_CYCLES(ERASE)
  ) i_secure_cfg_access (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .addr(addr),
    .wrData(wrData), .sigWrData(sigWrData), .rdData(rdData), .rdValid(rdValid),
    .sigRdData(sigRdData), .sigValid(sigValid), .denied(denied), .busy(busy),
    .locked(locked)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit guardedOp(input logic [2:0] op);
    return (op == 3'd1) || (op == 3'd2) || (op == 3'd3) || (op == 3'd6);
  endfunction

  function automatic logic [DATA_W-1:0] expRead(input logic [2:0] op, input logic [ADDR_W-1:0] a);
    return (op == 3'd3 && !mLocked) ? mMem[a] : '0;
  endfunction

  task automatic modelErase();
    for (int i = 0; i < DEPTH; i++) mMem[i] = '1;
    mSig    = '1;
    mLocked = 1'b0;
  endtask

  task automatic drive(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [SIG_W-1:0] s);
    cmdValid = 1'b1; cmdOp = op; addr = a; wrData = d; sigWrData = s;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // Issue one command when not busy and check the response one cycle later.
  task automatic run(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d, input logic [SIG_W-1:0] s);
    logic [DATA_W-1:0] eRd;
    logic              eDen;
    logic [SIG_W-1:0]  eSig;
    string             tagRd;
    eRd   = expRead(op, a);
    eDen  = mLocked && guardedOp(op);
    eSig  = (op == 3'd7) ? mSig : '0;
    tagRd = mLocked ? "R4 verify refused" : "R2 verify data";
    if (!mLocked) begin
      if (op == 3'd1 || op == 3'd2) mMem[a] = d;
      if (op == 3'd6) mSig = s;
      if (op == 3'd2) mLocked = 1'b1;
    end
    if (op == 3'd4) mLocked = 1'b1;
    drive(op, a, d, s);
    check(tagRd, 64'(rdData), 64'(eRd));
    check("R2 rdValid", 64'(rdValid), 64'(op == 3'd3));
    check(eDen ? "R5 denied" : "R11 denied", 64'(denied), 64'(eDen));
    check("R8 sigValid", 64'(sigValid), 64'(op == 3'd7));
    check("R8 R10 sigRdData", sigRdData, eSig);
    check("R3 R11 locked", 64'(locked), 64'(mLocked));
    check("R6 busy", 64'(busy), 64'(op == 3'd5));
    if (op == 3'd5) eraseTail();
  endtask

  // Erase already accepted, busy seen once; fire commands into every busy cycle.
  task automatic eraseTail();
    for (int i = 1; i <= ERASE; i++) begin
      drive(3'($urandom_range(0, 7)), ADDR_W'($urandom), DATA_W'($urandom),
            {$urandom, $urandom});
      check("R7 no rdValid", 64'(rdValid), 64'd0);
      check("R7 no sigValid", 64'(sigValid), 64'd0);
      check("R7 no denied", 64'(denied), 64'd0);
      check("R6 busy length", 64'(busy), 64'(i < ERASE));
    end
    modelErase();
    check("R6 lock cleared", 64'(locked), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    modelErase();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 locked", 64'(locked), 64'd0);
    check("R1 rdValid", 64'(rdValid), 64'd0);
    check("R1 rdData", 64'(rdData), 64'd0);
    check("R1 denied", 64'(denied), 64'd0);
    check("R1 sigValid", 64'(sigValid), 64'd0);
    check("R1 sigRdData", sigRdData, 64'd0);
    for (int i = 0; i < DEPTH; i++) run(3'd3, ADDR_W'(i), '0, '0);   // R1 words blank
    run(3'd7, '0, '0, '0);                                             // R1 signature blank
    // R2 program and verify every word
    for (int i = 0; i < DEPTH; i++) run(3'd1, ADDR_W'(i), DATA_W'(8'h30 + i), '0);
    for (int i = 0; i < DEPTH; i++) run(3'd3, ADDR_W'(i), '0, '0);
    // R9 R10 full-width signature
    run(3'd6, '0, '0, 64'hA5C3_0F1E_7788_9911);
    run(3'd7, '0, '0, '0);
    check("R10 width", 64'(SIG_W), 64'($bits(sigRdData)));
    run(3'd0, 3'd2, 8'h55, 64'd7);                                     // R11 nop
    // R3 program-and-lock
    run(3'd2, 3'd5, 8'hC7, '0);
    run(3'd3, 3'd5, '0, '0);                                           // R4 refused
    run(3'd1, 3'd5, 8'h11, '0);                                        // R5 refused
    run(3'd6, '0, '0, 64'h1234);                                       // R5 refused sig
    run(3'd7, '0, '0, '0);                                             // R8 readable locked
    run(3'd4, '0, '0, '0);                                             // R11 lock again
    run(3'd5, '0, '0, '0);                                             // R6 erase
    for (int i = 0; i < DEPTH; i++) run(3'd3, ADDR_W'(i), '0, '0);     // R6 blank
    run(3'd7, '0, '0, '0);
    // R3 plain lock after program
    run(3'd1, 3'd1, 8'h9A, '0);
    run(3'd4, '0, '0, '0);
    run(3'd3, 3'd1, '0, '0);
    run(3'd5, '0, '0, '0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op == 3'd5 && ($urandom_range(0, 3) != 0)) op = 3'd3;
      run(op, ADDR_W'($urandom), DATA_W'($urandom), {$urandom, $urandom});
    end
    for (int i = 0; i < DEPTH; i++) run(3'd3, ADDR_W'(i), '0, '0);
    run(3'd7, '0, '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule